// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns host control signals into the 6-bit state word for a binary-weighted step attenuator. Bit 0 of the word is the finest step, at 0.5 dB. Each higher bit doubles the weight, so bit 5 is worth 16 dB. A word of all zeros selects reference loss, and all ones selects 31.5 dB.

A source-select input picks one of two sources. The first is a six-line parallel word. The second is a three-wire serial port with data, serial clock and latch-enable inputs. Serial bits enter a shift register. That register and the parallel word share a single level-sensitive hold stage, which is controlled by latch-enable. While latch-enable is high, the hold stage is transparent and the output follows the selected source. While latch-enable is low, the output is frozen.

Everything runs on one system clock. The serial clock, serial data and latch-enable inputs pass through a synchronizer before use. The parallel word is assumed to be quasi-static with respect to the system clock. Besides the raw state word, the block outputs the attenuation as a count of half-dB steps.

Top module: `atten_ctrl`

## Requirements
- R1: `src_serial` low routes the parallel word `par_word` to the hold stage, and high routes the serial shift register to it. The choice applies on the next load.
- R2: Bit k of `att_state` carries a weight of 0.5·2^k dB. `att_halfdb` equals `att_state` read as an unsigned integer, from 0 for reference loss up to 63 for 31.5 dB.
- R3: Serial bits enter most-significant first. After six rising serial-clock edges, the first bit sent sits in bit 5 (16 dB) and the last bit sent sits in bit 0.
- R4: The shift register advances on every synchronized rising edge of `ser_clk`, whatever the level of `ser_le`. Shifting while `ser_le` is low leaves `att_state` unchanged.
- R5: In serial mode with `ser_le` high, `att_state` follows the shift register contents, including partially shifted words.
- R6: While the synchronized `ser_le` is low, `att_state` holds its value. Changes on `par_word`, on `src_serial` or in the shift register have no effect on it.
- R7: In latched parallel use, a high-then-low pulse on `ser_le` loads the current `par_word` into `att_state`.
- R8: In direct parallel use, with `ser_le` held high, every change on `par_word` appears on `att_state` within SYNC_STAGES+1 system clocks.
- R9: While `rst_n` is low, the shift register, the synchronizers and `att_state` clear to zero, which is reference loss.
- R10: Changing `src_serial` does not clear or alter the shift register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_serial | input | 1 | Source select: 0 parallel, 1 serial |
| par_word | input | ATT_BITS | Parallel attenuation word |
| ser_data | input | 1 | Serial data, MSB first |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_le | input | 1 | Latch enable: high transparent, low hold |
| att_state | output | ATT_BITS | Attenuation state word driving the switches |
| att_halfdb | output | ATT_BITS | Attenuation in 0.5 dB steps |

## Verification
The bench builds the block at its defaults, ATT_BITS = 6 and SYNC_STAGES = 2. At this width a word of all ones reaches the top code of 63. With two synchronizer stages, the latency of both a latch-enable pulse and a serial edge is short enough that directed sequences can check the hold, transparent and direct phases at fixed settle points. The chosen serial words read differently when bit-reversed, so the bench can tell MSB-first order from LSB-first order, and partial shifts under a transparent latch stay visible at the output.

// File: rtl/atten_ctrl_pkg.sv
// Package: shared defaults and the source-select encoding for the
// attenuator control front end. Assumes nothing beyond its users.
package atten_ctrl_pkg;
    localparam int unsigned ATT_BITS_DEF    = 6;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic {
        SRC_PARALLEL = 1'b0,
        SRC_SERIAL   = 1'b1
    } src_sel_e;
endpackage

// File: rtl/atten_sync.sv
// Module: multi-bit level synchronizer. Each bit passes through STAGES
// flops. The bits are assumed to be independent levels, or slow enough
// that skew between them is harmless.
module atten_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture flop for the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/atten_shift.sv
// Module: serial-in parallel-out shift register. It advances on a rising
// edge of the synchronized serial clock and shifts MSB first (new bits
// enter at bit 0). The inputs must already be synchronized, with data and
// clock delayed equally.
module atten_shift #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         sdata_s,
    output logic         step,
    output logic [W-1:0] shreg
);
    logic sclk_d;

    // Purpose: remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign step = sclk_s & ~sclk_d;

    // Purpose: shift one bit in on each detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (step) shreg <= {shreg[W-2:0], sdata_s};
    end
endmodule

// File: rtl/atten_hold.sv
// Module: level-sensitive hold stage modelled as an enable-gated register.
// While open is high, the stage reloads from d on every clock. While open
// is low, it keeps its value.
module atten_hold #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: transparent-when-open state register.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (open) q <= d;
    end
endmodule

// File: rtl/atten_ctrl.sv
// Module: top of the step attenuator control front end. It synchronizes
// the serial clock, serial data and latch enable, shifts serial bits in,
// selects the serial or parallel word and holds it under latch-enable
// control. par_word and src_serial are assumed quasi-static with respect
// to clk.
module atten_ctrl
    import atten_ctrl_pkg::*;
#(
    parameter int unsigned ATT_BITS    = ATT_BITS_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_serial,
    input  logic [ATT_BITS-1:0] par_word,
    input  logic                ser_data,
    input  logic                ser_clk,
    input  logic                ser_le,
    output logic [ATT_BITS-1:0] att_state,
    output logic [ATT_BITS-1:0] att_halfdb
);
    localparam int unsigned SYNC_W = 3;

    logic [SYNC_W-1:0]   async_in;
    logic [SYNC_W-1:0]   sync_out;
    logic                sclk_sync;
    logic                sdata_sync;
    logic                le_sync;
    logic                shift_step;
    logic [ATT_BITS-1:0] shreg;
    logic [ATT_BITS-1:0] hold_d;
    src_sel_e            src_sel;

    assign async_in   = {ser_clk, ser_data, ser_le};
    assign sclk_sync  = sync_out[2];
    assign sdata_sync = sync_out[1];
    assign le_sync    = sync_out[0];
    assign src_sel    = src_sel_e'(src_serial);

    atten_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );

    atten_shift #(.W(ATT_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_sync),
        .sdata_s (sdata_sync),
        .step    (shift_step),
        .shreg   (shreg)
    );

    // Purpose: pick the word that feeds the hold stage.
    always_comb begin
        case (src_sel)
            SRC_SERIAL: hold_d = shreg;
            default:    hold_d = par_word;
        endcase
    end

    atten_hold #(.W(ATT_BITS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .open  (le_sync),
        .d     (hold_d),
        .q     (att_state)
    );

    // Binary weights make the half-dB count equal to the word itself.
    assign att_halfdb = att_state;
endmodule

// File: rtl/atten_ctrl_chk.sv
// Module: assertion checker for atten_ctrl, attached through bind. It
// observes the synchronized latch enable, the shift register and the
// output state.
module atten_ctrl_chk #(
    parameter int unsigned W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         src_serial,
    input logic [W-1:0] par_word,
    input logic         le_sync,
    input logic         shift_step,
    input logic         sdata_sync,
    input logic [W-1:0] shreg,
    input logic [W-1:0] att_state
);
    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !le_sync |=> $stable(att_state)); // R6

    AST_SERIAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (le_sync && src_serial) |=> (att_state == $past(shreg))); // R5

    AST_PARALLEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (le_sync && !src_serial) |=> (att_state == $past(par_word))); // R8

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_step |=> $stable(shreg)); // R4

    AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        shift_step |=> (shreg == {$past(shreg[W-2:0]), $past(sdata_sync)})); // R3
endmodule

bind atten_ctrl atten_ctrl_chk #(.W(ATT_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_serial (src_serial),
    .par_word   (par_word),
    .le_sync    (le_sync),
    .shift_step (shift_step),
    .sdata_sync (sdata_sync),
    .shreg      (shreg),
    .att_state  (att_state)
);

// File: tb/atten_ctrl_test.sv
// Bench: directed scenarios for atten_ctrl, one task per scenario.
module atten_ctrl_test;
    localparam int unsigned W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         src_serial = 1'b0;
    logic [W-1:0] par_word = '0;
    logic         ser_data = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_le = 1'b0;
    logic [W-1:0] att_state;
    logic [W-1:0] att_halfdb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    atten_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_serial (src_serial),
        .par_word   (par_word),
        .ser_data   (ser_data),
        .ser_clk    (ser_clk),
        .ser_le     (ser_le),
        .att_state  (att_state),
        .att_halfdb (att_halfdb)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_clk(4);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
        wait_clk(4);
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
        wait_clk(4);
    endtask

    task automatic t_reset();
        check("R9 state", att_state, '0);
        check("R9 halfdb", att_halfdb, '0);
    endtask

    task automatic t_direct_parallel();
        src_serial = 1'b0;
        ser_le = 1'b1;
        par_word = 6'd21;
        wait_clk(8);
        check("R8 direct 21", att_state, 6'd21);
        par_word = 6'd42;
        wait_clk(8);
        check("R8 direct 42", att_state, 6'd42);
        check("R2 halfdb 42", att_halfdb, 6'd42);
    endtask

    task automatic t_latched_parallel();
        ser_le = 1'b0;
        wait_clk(8);
        par_word = 6'd3;
        wait_clk(8);
        check("R6 hold vs par_word", att_state, 6'd42);
        pulse_le();
        check("R7 latched load", att_state, 6'd3);
    endtask

    task automatic t_serial_latched();
        src_serial = 1'b1;
        wait_clk(8);
        check("R6 hold vs mode", att_state, 6'd3);
        shift_word(6'b110100);
        check("R4 shift with le low", att_state, 6'd3);
        pulse_le();
        check("R3 msb first", att_state, 6'd52);
        check("R1 serial source", att_halfdb, 6'd52);
    endtask

    task automatic t_serial_transparent();
        ser_le = 1'b1;
        wait_clk(8);
        check("R5 open follow", att_state, 6'd52);
        shift_bit(1'b1);
        shift_bit(1'b0);
        wait_clk(4);
        check("R5 partial shift", att_state, 6'd18);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic t_mode_keeps_shreg();
        shift_word(6'b011101);
        check("R6 hold vs shift", att_state, 6'd18);
        src_serial = 1'b0;
        par_word = 6'd9;
        wait_clk(4);
        pulse_le();
        check("R1 parallel source", att_state, 6'd9);
        src_serial = 1'b1;
        wait_clk(4);
        pulse_le();
        check("R10 shreg kept", att_state, 6'd29);
    endtask

    task automatic t_extremes();
        src_serial = 1'b0;
        ser_le = 1'b1;
        par_word = 6'd63;
        wait_clk(8);
        check("R2 all ones state", att_state, 6'd63);
        check("R2 all ones halfdb", att_halfdb, 6'd63);
        par_word = 6'd0;
        wait_clk(8);
        check("R2 reference loss", att_halfdb, 6'd0);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(2);
        t_direct_parallel();
        t_latched_parallel();
        t_serial_latched();
        t_serial_transparent();
        t_mode_keeps_shreg();
        t_extremes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule